// File: doc/BRIEF.md
# Completion Ring Producer Engine

The engine takes completion entries offered on a user event stream and places them, one at a time, into a completion ring that lives in host memory. The ring is described by a per-queue context: a 64-byte aligned base address, an entry size code, a port identifier, a valid flag and an overflow-check-disable flag. The ring size and the consumer index arrive as inputs. The block itself owns the producer index, the color bit and the error state.

Each accepted event is screened in a fixed order. An event is dropped and the port-error flag is raised when the context is invalid or the event's port identifier differs from the context's. When overflow checking is active and the ring is full, the event is dropped and the error code is latched. Any other event becomes a write request on a simple request/acknowledge port. That request carries the computed ring address, the entry data and the current color. The producer index moves forward when the write is acknowledged. The color bit inverts each time the producer index wraps to zero. A context load pulse resets the per-queue state before the queue is used.

Top module: `cring_producer`

## Requirements
- R1: After reset, pidx is 0, color is 0, err_code is 0, port_err is 0 and wr_req is 0.
- R2: A cycle with ctx_load high sets pidx to 0, color to ctx_color_init, err_code to 0 and port_err to 0, and clears wr_req. ev_ready is low in that cycle.
- R3: An event accepted (ev_valid and ev_ready) while ctx_valid is 0, or whose ev_port differs from ctx_port, produces no write. It sets port_err to 1 and leaves pidx and err_code unchanged.
- R4: With ctx_ovf_off 0, the ring is full when the advanced producer index equals cidx. An event accepted with matching port while the ring is full produces no write, and err_code becomes 3 (code 0 means no error).
- R5: With ctx_ovf_off 1, an event with matching port is written even when the full condition holds, and err_code is not changed.
- R6: wr_addr equals ctx_base shifted left by 6, plus pidx shifted left by 3 + ctx_esz. ctx_esz codes 0, 1, 2 and 3 mean 8, 16, 32 and 64 byte entries.
- R7: A write request appears in the cycle after acceptance. wr_data equals the event's ev_data and wr_color equals color at acceptance.
- R8: On a cycle with wr_req and wr_ack, pidx advances by one. From ring_size-1 it goes to 0 instead, and in that case color inverts.
- R9: While wr_req is high and wr_ack is low, wr_req, wr_addr and wr_data hold, ev_ready is low, and pidx is unchanged.
- R10: When a port mismatch and a full ring coincide for one event, only the port check acts: port_err becomes 1 and err_code keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctx_load | input | 1 | Initialise queue state |
| ctx_color_init | input | 1 | Color loaded by ctx_load |
| ctx_valid | input | 1 | Context is valid |
| ctx_port | input | 3 | Port identifier of the queue |
| ctx_ovf_off | input | 1 | Disable full-ring test |
| ctx_esz | input | 2 | Entry size code |
| ctx_base | input | 58 | Ring base address bits 63:6 |
| ring_size | input | PIDX_W | Number of ring slots |
| cidx | input | PIDX_W | Consumer index |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event can be taken |
| ev_port | input | 3 | Port identifier of the event |
| ev_data | input | DW | Completion entry payload |
| wr_req | output | 1 | Host write request |
| wr_addr | output | 64 | Host write byte address |
| wr_data | output | DW | Host write payload |
| wr_color | output | 1 | Color stamped on the entry |
| wr_ack | input | 1 | Host write accepted |
| pidx | output | PIDX_W | Producer index |
| color | output | 1 | Current color |
| err_code | output | 2 | Latched context error code |
| port_err | output | 1 | Sticky port/validity error flag |

## Verification
Two checks meet in one cycle for a single event: the port/validity screen and the full-ring test. The bench sets up that overlap by loading a context and then placing cidx one slot ahead of pidx, so the ring is full. It then sends an event with a mismatched port identifier. It expects only port_err to rise, err_code to stay 0 and no write request to appear. A second overlap, where the acknowledge lands on the wrap slot, is judged by the index going to zero and the color inverting in the same update.

// File: rtl/cring_pkg.sv
package cring_pkg;
  localparam int ADDR_W   = 64;
  localparam int BASE_W   = ADDR_W - 6;
  localparam int PORT_W   = 3;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_CIDX = 2'd1,
    ERR_DESC = 2'd2,
    ERR_FULL = 2'd3
  } cring_err_e;
endpackage

// File: rtl/cring_admit.sv
module cring_admit #(
  parameter int PIDX_W = 16,
  parameter int PORT_W = 3
) (
  input  logic              ctx_valid,
  input  logic [PORT_W-1:0] ctx_port,
  input  logic [PORT_W-1:0] ev_port,
  input  logic [PIDX_W-1:0] pidx,
  input  logic [PIDX_W-1:0] ring_size,
  input  logic [PIDX_W-1:0] cidx,
  output logic              port_bad,
  output logic              ring_full,
  output logic              wrap,
  output logic [PIDX_W-1:0] pidx_nxt
);
  localparam logic [PIDX_W-1:0] ONE = PIDX_W'(1);

  always_comb begin
    wrap      = (pidx == (ring_size - ONE));
    pidx_nxt  = wrap ? '0 : (pidx + ONE);
    ring_full = (pidx_nxt == cidx);
    port_bad  = !ctx_valid || (ev_port != ctx_port);
  end
endmodule

// File: rtl/cring_ptr.sv
module cring_ptr #(
  parameter int PIDX_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              color_init,
  input  logic              advance,
  input  logic              wrap,
  input  logic [PIDX_W-1:0] pidx_nxt,
  output logic [PIDX_W-1:0] pidx,
  output logic              color
);
  logic [PIDX_W-1:0] pidx_d;
  logic              color_d;
  logic              en;

  always_comb begin
    en      = load || advance;
    pidx_d  = load ? '0 : pidx_nxt;
    color_d = load ? color_init : (wrap ? !color : color);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pidx  <= '0;
      color <= 1'b0;
    end else if (en) begin
      pidx  <= pidx_d;
      color <= color_d;
    end
  end
endmodule

// File: rtl/cring_addr.sv
module cring_addr #(
  parameter int PIDX_W = 16,
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-7:0] base,
  input  logic [1:0]        esz,
  input  logic [PIDX_W-1:0] pidx,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] idx_ext;
  logic [ADDR_W-1:0] offs;

  always_comb begin
    idx_ext = ADDR_W'(pidx);
    offs    = idx_ext << (3 + esz);
    addr    = {base, 6'b0} + offs;
  end
endmodule

// File: rtl/cring_producer.sv
module cring_producer
  import cring_pkg::*;
#(
  parameter int PIDX_W = 16,
  parameter int DW     = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctx_load,
  input  logic              ctx_color_init,
  input  logic              ctx_valid,
  input  logic [2:0]        ctx_port,
  input  logic              ctx_ovf_off,
  input  logic [1:0]        ctx_esz,
  input  logic [57:0]       ctx_base,
  input  logic [PIDX_W-1:0] ring_size,
  input  logic [PIDX_W-1:0] cidx,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [2:0]        ev_port,
  input  logic [DW-1:0]     ev_data,
  output logic              wr_req,
  output logic [63:0]       wr_addr,
  output logic [DW-1:0]     wr_data,
  output logic              wr_color,
  input  logic              wr_ack,
  output logic [PIDX_W-1:0] pidx,
  output logic              color,
  output logic [1:0]        err_code,
  output logic              port_err
);
  logic              port_bad, ring_full, wrap;
  logic [PIDX_W-1:0] pidx_nxt;
  logic [ADDR_W-1:0] slot_addr;
  logic              accept, blocked, take, advance;
  logic              req_d, perr_d;
  logic [1:0]        err_d;

  cring_admit #(.PIDX_W(PIDX_W), .PORT_W(PORT_W)) u_admit (
    .ctx_valid (ctx_valid),
    .ctx_port  (ctx_port),
    .ev_port   (ev_port),
    .pidx      (pidx),
    .ring_size (ring_size),
    .cidx      (cidx),
    .port_bad  (port_bad),
    .ring_full (ring_full),
    .wrap      (wrap),
    .pidx_nxt  (pidx_nxt)
  );

  cring_addr #(.PIDX_W(PIDX_W), .ADDR_W(ADDR_W)) u_addr (
    .base (ctx_base),
    .esz  (ctx_esz),
    .pidx (pidx),
    .addr (slot_addr)
  );

  cring_ptr #(.PIDX_W(PIDX_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (ctx_load),
    .color_init (ctx_color_init),
    .advance    (advance),
    .wrap       (wrap),
    .pidx_nxt   (pidx_nxt),
    .pidx       (pidx),
    .color      (color)
  );

  // Screening order: port/validity first, then full ring, then write.
  always_comb begin
    ev_ready = !wr_req && !ctx_load;
    accept   = ev_valid && ev_ready;
    blocked  = ring_full && !ctx_ovf_off;
    take     = accept && !port_bad && !blocked;
    advance  = wr_req && wr_ack && !ctx_load;
    req_d    = wr_req;
    err_d    = err_code;
    perr_d   = port_err;
    if (ctx_load) begin
      req_d  = 1'b0;
      err_d  = ERR_NONE;
      perr_d = 1'b0;
    end else begin
      if (advance) req_d = 1'b0;
      if (accept) begin
        if (port_bad)     perr_d = 1'b1;
        else if (blocked) err_d  = ERR_FULL;
        else              req_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_req   <= 1'b0;
      err_code <= ERR_NONE;
      port_err <= 1'b0;
    end else begin
      wr_req   <= req_d;
      err_code <= err_d;
      port_err <= perr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_color <= 1'b0;
    end else if (take) begin
      wr_addr  <= slot_addr;
      wr_data  <= ev_data;
      wr_color <= color;
    end
  end
endmodule

// File: rtl/cring_producer_chk.sv
module cring_producer_chk #(
  parameter int PIDX_W = 16,
  parameter int DW     = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctx_load,
  input logic              ctx_valid,
  input logic [2:0]        ctx_port,
  input logic              ctx_ovf_off,
  input logic [PIDX_W-1:0] ring_size,
  input logic [PIDX_W-1:0] cidx,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic [2:0]        ev_port,
  input logic              wr_req,
  input logic [63:0]       wr_addr,
  input logic [DW-1:0]     wr_data,
  input logic              wr_ack,
  input logic [PIDX_W-1:0] pidx,
  input logic              color,
  input logic [1:0]        err_code,
  input logic              port_err
);
  logic [PIDX_W-1:0] nxt;
  logic              at_end, ok_port;
  always_comb begin
    at_end  = (pidx == ring_size - PIDX_W'(1));
    nxt     = at_end ? '0 : pidx + PIDX_W'(1);
    ok_port = ctx_valid && (ev_port == ctx_port);
  end

  AST_LOAD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_load |=> (pidx == '0) && (err_code == 2'd0) && !port_err && !wr_req); // R2
  AST_PORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && !ok_port |=> port_err && !wr_req); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && ok_port && !ctx_ovf_off && (nxt == cidx)
    |=> (err_code == 2'd3) && !wr_req); // R4
  AST_PIDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_ack && !ctx_load |=> pidx == $past(nxt)); // R8
  AST_COLOR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_ack && !ctx_load && at_end |=> color != $past(color)); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack && !ctx_load
    |=> wr_req && $stable(wr_addr) && $stable(wr_data) && $stable(pidx)); // R9
  AST_BUSY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> !ev_ready); // R9
endmodule

bind cring_producer cring_producer_chk #(.PIDX_W(PIDX_W), .DW(DW)) u_chk (.*);

// File: tb/sim_cring_producer.sv
module sim_cring_producer;
  localparam int PW = 16;
  localparam int DW = 64;

  logic          clk, rst_n;
  logic          ctx_load, ctx_color_init, ctx_valid, ctx_ovf_off;
  logic [2:0]    ctx_port, ev_port;
  logic [1:0]    ctx_esz;
  logic [57:0]   ctx_base;
  logic [PW-1:0] ring_size, cidx;
  logic          ev_valid, ev_ready, wr_req, wr_color, wr_ack, color, port_err;
  logic [DW-1:0] ev_data, wr_data;
  logic [63:0]   wr_addr;
  logic [PW-1:0] pidx;
  logic [1:0]    err_code;

  int n_cmp = 0, n_bad = 0;
  logic [PW-1:0] e_pidx;
  logic          e_color;

  cring_producer #(.PIDX_W(PW), .DW(DW)) u0 (.*);

  initial clk = 1'b0;
  always #10 clk = !clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_ctx(input logic cinit);
    @(negedge clk); ctx_load = 1'b1; ctx_color_init = cinit;
    @(negedge clk); ctx_load = 1'b0;
    e_pidx = '0; e_color = cinit;
  endtask

  task automatic push(input logic [2:0] p, input logic [DW-1:0] d);
    @(negedge clk); ev_valid = 1'b1; ev_port = p; ev_data = d;
    @(negedge clk); ev_valid = 1'b0;
  endtask

  task automatic ack_once();
    wr_ack = 1'b1;
    @(negedge clk); wr_ack = 1'b0;
    if (e_pidx == ring_size - 1) begin e_pidx = '0; e_color = !e_color; end
    else e_pidx = e_pidx + 1;
  endtask

  initial begin
    #4_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctx_load = 0; ctx_color_init = 0; ctx_valid = 1; ctx_ovf_off = 0;
    ctx_port = 3'd2; ev_port = 3'd2; ctx_esz = 0; ctx_base = 58'h123; ring_size = 4;
    cidx = 0; ev_valid = 0; ev_data = '0; wr_ack = 0;
    repeat (3) @(negedge clk);
    chk("R1 pidx", 64'(pidx), 0);
    chk("R1 color", 64'(color), 0);
    chk("R1 err", 64'(err_code), 0);
    chk("R1 port_err", 64'(port_err), 0);
    chk("R1 wr_req", 64'(wr_req), 0);
    rst_n = 1'b1;

    // Sweep: ring sizes, entry size codes, several wraps
    for (int rs = 2; rs <= 5; rs++) begin
      for (int sz = 0; sz < 4; sz++) begin
        ring_size = PW'(rs); ctx_esz = 2'(sz);
        ctx_base = 58'h40 + 58'(rs * 7 + sz);
        load_ctx(1'b1);
        chk("R2 color_init", 64'(color), 1);
        for (int i = 0; i < 2 * rs + 1; i++) begin
          logic [DW-1:0] d;
          d = {32'(rs), 16'(sz), 16'(i)} ^ 64'h5a5a_0000_0000_0000;
          cidx = e_pidx;
          push(3'd2, d);
          chk("R7 wr_req", 64'(wr_req), 1);
          chk("R6 addr", wr_addr, {ctx_base, 6'b0} + (64'(e_pidx) << (3 + sz)));
          chk("R7 data", wr_data, d);
          chk("R7 color", 64'(wr_color), 64'(e_color));
          chk("R9 ready low", 64'(ev_ready), 0);
          ack_once();
          chk("R8 pidx", 64'(pidx), 64'(e_pidx));
          chk("R8 color", 64'(color), 64'(e_color));
          chk("R8 req drop", 64'(wr_req), 0);
        end
      end
    end

    // Hold while not acknowledged
    ring_size = 4; ctx_esz = 2'd1; load_ctx(1'b0); cidx = 0;
    push(3'd2, 64'hABCD);
    repeat (3) @(negedge clk);
    chk("R9 hold req", 64'(wr_req), 1);
    chk("R9 hold addr", wr_addr, {ctx_base, 6'b0});
    chk("R9 hold pidx", 64'(pidx), 0);
    ack_once();
    chk("R8 pidx after hold", 64'(pidx), 1);

    // Full ring with check enabled
    load_ctx(1'b0); cidx = 1;
    push(3'd2, 64'h1);
    chk("R4 no write", 64'(wr_req), 0);
    chk("R4 err full", 64'(err_code), 3);
    chk("R4 pidx", 64'(pidx), 0);

    // Full ring with check disabled
    load_ctx(1'b0); ctx_ovf_off = 1'b1;
    push(3'd2, 64'h2);
    chk("R5 write", 64'(wr_req), 1);
    chk("R5 err", 64'(err_code), 0);
    ack_once();
    chk("R5 pidx", 64'(pidx), 1);
    ctx_ovf_off = 1'b0;

    // Port mismatch
    load_ctx(1'b0); cidx = 0;
    push(3'd5, 64'h3);
    chk("R3 no write", 64'(wr_req), 0);
    chk("R3 port_err", 64'(port_err), 1);
    chk("R3 pidx", 64'(pidx), 0);
    chk("R3 err", 64'(err_code), 0);

    // Invalid context
    load_ctx(1'b0); ctx_valid = 1'b0;
    push(3'd2, 64'h4);
    chk("R3 invalid no write", 64'(wr_req), 0);
    chk("R3 invalid port_err", 64'(port_err), 1);
    ctx_valid = 1'b1;

    // Clear by load
    load_ctx(1'b1);
    chk("R2 port_err clr", 64'(port_err), 0);
    chk("R2 pidx", 64'(pidx), 0);

    // Mismatch and full at once
    cidx = 1;
    push(3'd6, 64'h5);
    chk("R10 port_err", 64'(port_err), 1);
    chk("R10 err kept", 64'(err_code), 0);
    chk("R10 no write", 64'(wr_req), 0);

    // Load during pending write
    cidx = 0;
    push(3'd2, 64'h6);
    chk("R2 pend req", 64'(wr_req), 1);
    @(negedge clk); ctx_load = 1'b1; ctx_color_init = 1'b0;
    chk("R2 ready low", 64'(ev_ready), 0);
    @(negedge clk); ctx_load = 1'b0;
    chk("R2 req cleared", 64'(wr_req), 0);
    chk("R2 color", 64'(color), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule